// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Break and Idle Frames

This block is the transmit half of an asynchronous serial port. A processor writes words through a data-write strobe. If the line is free, the word goes straight into the output shifter. If a frame is already on the wire, the word is parked in a one-word holding register, and it moves into the shifter the moment the current frame ends. The two flags on the output side tell the processor two things. The empty flag says the holding register can take another word. The complete flag says a frame has finished.

Besides data frames the block can put whole frames of constant level on the line. An all-ones idle frame is sent whenever transmission is enabled. An all-zeros break frame repeats for as long as break is requested. When break is released, the block sends one extra marking bit so that a receiver can find the next start edge. Bit timing comes from an external oversampling tick. Each bit lasts sixteen ticks. One interrupt line combines the two flags with their enables and a global mask.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `tdre` is 1, `tc` is 1 and `irq` is 0 when all enables are 0.
- R2: A data frame is a 0 start bit, then data bits least significant first, then a 1 stop bit. With `nine_bit`=0 it carries `data_in[7:0]` (10 bit times). With `nine_bit`=1 it carries `data_in[8:0]` (11 bit times).
- R3: Every bit of every frame lasts exactly 16 cycles in which `baud_tick` is 1. Cycles without a tick do not advance the line.
- R4: A `data_wr` while `tx_en`=1, no frame in flight and no other frame pending shows the start bit on `txd` in the next cycle, and `tdre` reads 1 in that same cycle.
- R5: A `data_wr` while a frame is in flight is held. Its start bit follows the previous stop bit with no gap, and `tdre` returns to 1 when it leaves the holding register.
- R6: `tdre` and `tc` are cleared only by a `data_wr` that follows a `stat_rd` with no `data_wr` between them. A `data_wr` without such a prior `stat_rd` leaves both flags unchanged. A direct load as in R4 leaves `tdre` at 1.
- R7: `tc` goes to 1 when a data frame, idle frame or break frame ends.
- R8: `irq` = !`irq_mask` && ((`tdre_ie` && `tdre`) || (`tc_ie` && `tc`)).
- R9: While `send_break` is 1 the block sends break frames back to back. Each break frame holds `txd` at 0 for 10 bit times (`nine_bit`=0) or 11 bit times (`nine_bit`=1).
- R10: After `send_break` returns to 0, the last break frame is followed by exactly one bit time of 1, and the next frame starts right after that bit.
- R11: A 0-to-1 change of `tx_en` makes the block send one idle frame (all ones, full frame length) before any data frame.
- R12: Clearing and then setting `tx_en` while a frame is in flight sends an idle frame right after that frame, ahead of any held word.
- R13: While `tx_en` is 0 no new frame starts. A written word waits in the holding register, and `txd` stays 1 when no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| tx_en | input | 1 | Transmit enable; a rising edge queues an idle frame |
| send_break | input | 1 | Request break frames |
| nine_bit | input | 1 | Word length select: 0 = 8 bits, 1 = 9 bits |
| tdre_ie | input | 1 | Interrupt enable for the empty flag |
| tc_ie | input | 1 | Interrupt enable for the complete flag |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| stat_rd | input | 1 | Status access strobe; arms the flag clear |
| data_wr | input | 1 | Data write strobe |
| data_in | input | 9 | Word to transmit |
| txd | output | 1 | Serial output, idles at 1 |
| tdre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong frame scheduling state shows on `txd` as a misplaced start edge. A missed marking bit or a dropped idle frame moves the next start bit by a whole bit or frame time, and it is visible within one frame of the cause. A lost or stale holding-register state shows either as a missing frame or as a repeated word, and also as `tdre` failing to return to 1 at the frame boundary. An error in the clear-arming state shows one cycle after the data write, as a flag that drops when it should hold or holds when it should drop. An error in the tick counter stretches or shrinks a bit, and the mid-bit sampling of the following bits exposes it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int WORD_W  = 9;
    localparam int FRAME_W = WORD_W + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_IDLE  = 2'd1,
        FK_BREAK = 2'd2,
        FK_MARK  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e            kind;
        logic [FRAME_W-1:0]     bits;   // sent LSB first
        logic [LEN_W-1:0]       len;    // bit times
    } frame_t;

    function automatic logic [LEN_W-1:0] frame_len(input logic nine);
        return nine ? LEN_W'(FRAME_W) : LEN_W'(FRAME_W - 1);
    endfunction

    function automatic frame_t build_frame(input frame_kind_e kind,
                                           input logic        nine,
                                           input logic [WORD_W-1:0] word);
        frame_t f;
        f.kind = kind;
        f.len  = frame_len(nine);
        case (kind)
            FK_DATA:  f.bits = nine ? {1'b1, word, 1'b0}
                                    : {2'b11, word[WORD_W-2:0], 1'b0};
            FK_IDLE:  f.bits = '1;
            FK_BREAK: f.bits = '0;
            default: begin
                f.bits = '1;
                f.len  = LEN_W'(1);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        baud_tick,
    input  logic        start,
    input  frame_t      nxt,
    output logic        busy,
    output logic        frame_end,
    output frame_kind_e kind,
    output logic        txd
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [SUB_W-1:0]   sub_q;
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    logic               busy_q;
    frame_kind_e        kind_q;
    logic               bit_end;

    assign bit_end   = busy_q && baud_tick && (sub_q == SUB_W'(OVS - 1));
    assign frame_end = bit_end && (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sub_q  <= '0;
            sh_q   <= '1;
            left_q <= '0;
            kind_q <= FK_IDLE;
        end else begin
            if (busy_q && baud_tick) begin
                if (bit_end) begin
                    sub_q  <= '0;
                    sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                    left_q <= left_q - LEN_W'(1);
                    if (left_q == LEN_W'(1)) busy_q <= 1'b0;
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
            end
            if (start) begin
                busy_q <= 1'b1;
                sh_q   <= nxt.bits;
                left_q <= nxt.len;
                sub_q  <= '0;
                kind_q <= nxt.kind;
            end
        end
    end

    assign busy = busy_q;
    assign kind = kind_q;
    assign txd  = busy_q ? sh_q[0] : 1'b1;

    // R3: without a tick the line level cannot move mid-frame
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !baud_tick && !start) |=> $stable(txd));

    // R9: a break frame drives zero for its whole length
    p_break_low_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && kind_q == FK_BREAK) |-> !txd);

    // R2: a freshly started data frame opens with a zero start bit
    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_q) && kind_q == FK_DATA) |-> !txd);

endmodule

// File: rtl/uart_tx_sched.sv
module uart_tx_sched
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              send_break,
    input  logic              nine_bit,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] data_in,
    input  logic              free,
    output logic              start,
    output frame_t            nxt,
    output logic              load_evt,
    output logic              wr_direct
);
    logic              te_q;
    logic              idle_pend_q;
    logic              brk_tail_q;
    logic              hold_full_q;
    logic [WORD_W-1:0] hold_q;
    logic              te_rise;
    logic              idle_req;
    logic              use_hold;
    frame_kind_e       kind_sel;
    logic [WORD_W-1:0] word_sel;

    assign te_rise  = tx_en && !te_q;
    assign idle_req = idle_pend_q || te_rise;

    // fixed priority at each frame boundary: break, marking bit, idle, held word, new word
    always_comb begin
        start     = 1'b0;
        use_hold  = 1'b0;
        wr_direct = 1'b0;
        kind_sel  = FK_IDLE;
        word_sel  = hold_q;
        if (free && tx_en) begin
            if (send_break) begin
                start    = 1'b1;
                kind_sel = FK_BREAK;
            end else if (brk_tail_q) begin
                start    = 1'b1;
                kind_sel = FK_MARK;
            end else if (idle_req) begin
                start    = 1'b1;
                kind_sel = FK_IDLE;
            end else if (hold_full_q) begin
                start    = 1'b1;
                kind_sel = FK_DATA;
                use_hold = 1'b1;
            end else if (data_wr) begin
                start     = 1'b1;
                kind_sel  = FK_DATA;
                wr_direct = 1'b1;
                word_sel  = data_in;
            end
        end
    end

    assign nxt      = build_frame(kind_sel, nine_bit, word_sel);
    assign load_evt = use_hold || wr_direct;

    always_ff @(posedge clk) begin
        if (rst) begin
            te_q        <= 1'b0;
            idle_pend_q <= 1'b0;
            brk_tail_q  <= 1'b0;
            hold_full_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            te_q <= tx_en;
            if (start && kind_sel == FK_IDLE)      idle_pend_q <= 1'b0;
            else if (te_rise)                      idle_pend_q <= 1'b1;
            if (start && kind_sel == FK_BREAK)     brk_tail_q  <= 1'b1;
            else if (start && kind_sel == FK_MARK) brk_tail_q  <= 1'b0;
            if (use_hold) hold_full_q <= 1'b0;
            if (data_wr && !wr_direct) begin
                hold_q      <= data_in;
                hold_full_q <= 1'b1;
            end
        end
    end

    // R5: a held word is kept until it is handed to the shifter
    p_hold_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_full_q && !use_hold) |=> hold_full_q);

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic stat_rd,
    input  logic data_wr,
    input  logic wr_direct,
    input  logic load_evt,
    input  logic frame_full_end,
    output logic tdre,
    output logic tc
);
    logic armed_q;
    logic tdre_q;
    logic tc_q;
    logic clr;

    assign clr = data_wr && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            tdre_q  <= 1'b1;
            tc_q    <= 1'b1;
        end else begin
            armed_q <= data_wr ? stat_rd : (armed_q || stat_rd);
            if (clr && !wr_direct) tdre_q <= 1'b0;
            else if (load_evt)     tdre_q <= 1'b1;
            if (clr)                 tc_q <= 1'b0;
            else if (frame_full_end) tc_q <= 1'b1;
        end
    end

    assign tdre = tdre_q;
    assign tc   = tc_q;

    // R4: a direct load leaves the empty flag set
    p_direct_tdre_r4: assert property (@(posedge clk) disable iff (rst)
        wr_direct |=> tdre_q);

    // R6: the empty flag only drops after an armed data write
    p_tdre_clear_armed_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tdre_q) |-> ($past(data_wr) && $past(armed_q)));

    // R6: the complete flag only drops after an armed data write
    p_tc_clear_armed_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tc_q) |-> ($past(data_wr) && $past(armed_q)));

    // R7: a finished frame raises the complete flag unless cleared at once
    p_tc_on_end_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_full_end && !clr) |=> tc_q);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              send_break,
    input  logic              nine_bit,
    input  logic              tdre_ie,
    input  logic              tc_ie,
    input  logic              irq_mask,
    input  logic              stat_rd,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] data_in,
    output logic              txd,
    output logic              tdre,
    output logic              tc,
    output logic              irq
);
    logic        busy;
    logic        frame_end;
    frame_kind_e kind;
    logic        start;
    frame_t      nxt;
    logic        load_evt;
    logic        wr_direct;
    logic        free;
    logic        frame_full_end;

    assign free           = !busy || frame_end;
    assign frame_full_end = frame_end && (kind != FK_MARK);

    uart_tx_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .send_break (send_break),
        .nine_bit   (nine_bit),
        .data_wr    (data_wr),
        .data_in    (data_in),
        .free       (free),
        .start      (start),
        .nxt        (nxt),
        .load_evt   (load_evt),
        .wr_direct  (wr_direct)
    );

    uart_tx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .start     (start),
        .nxt       (nxt),
        .busy      (busy),
        .frame_end (frame_end),
        .kind      (kind),
        .txd       (txd)
    );

    uart_tx_flags u_flags (
        .clk            (clk),
        .rst            (rst),
        .stat_rd        (stat_rd),
        .data_wr        (data_wr),
        .wr_direct      (wr_direct),
        .load_evt       (load_evt),
        .frame_full_end (frame_full_end),
        .tdre           (tdre),
        .tc             (tc)
    );

    assign irq = !irq_mask && ((tdre_ie && tdre) || (tc_ie && tc));

    // R8: the global mask silences the request
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> !irq);

    // R13: no frame begins while transmission is disabled
    p_start_needs_en_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_en));

endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic       tx_en, send_break, nine_bit;
    logic       tdre_ie, tc_ie, irq_mask;
    logic       stat_rd, data_wr;
    logic [8:0] data_in;
    logic       txd, tdre, tc, irq;

    int  checks = 0;
    int  errors = 0;
    bit  tick_mode = 1'b0;
    bit  rx_en = 1'b0;
    logic [9:0] exp_q[$];

    always #2 clk = ~clk;

    uart_tx_dbuf u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
        .send_break(send_break), .nine_bit(nine_bit), .tdre_ie(tdre_ie),
        .tc_ie(tc_ie), .irq_mask(irq_mask), .stat_rd(stat_rd),
        .data_wr(data_wr), .data_in(data_in), .txd(txd), .tdre(tdre),
        .tc(tc), .irq(irq)
    );

    always @(negedge clk) baud_tick <= tick_mode ? ~baud_tick : 1'b1;

    function automatic logic [10:0] frame_vec(input logic nine, input logic [8:0] d);
        return nine ? {1'b1, d, 1'b0} : {2'b11, d[7:0], 1'b0};
    endfunction

    function automatic logic exp_irq(input logic ie_e, input logic ie_c,
                                     input logic msk, input logic fe, input logic fc);
        return !msk && ((ie_e && fe) || (ie_c && fc));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // samples each bit at its centre; pre = negedges already spent in bit 0
    task automatic expect_frame(input logic [10:0] v, input int n, input int cpb,
                                input int pre, input string req);
        repeat (cpb / 2 - pre) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (cpb) @(negedge clk);
            chk(txd === v[i], req, int'(txd), int'(v[i]));
        end
        repeat (cpb - cpb / 2) @(negedge clk);
    endtask

    task automatic write_word(input bit armed, input logic [8:0] d);
        if (armed) begin
            stat_rd = 1'b1;
            @(negedge clk);
            stat_rd = 1'b0;
        end
        data_wr = 1'b1;
        data_in = d;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // serial receiver for the random phase
    initial begin
        logic [10:0] rv;
        logic [9:0]  e;
        int          rn;
        forever begin
            @(negedge clk);
            if (rx_en && txd === 1'b0) begin
                rn = nine_bit ? 11 : 10;
                rv = '1;
                repeat (8) @(negedge clk);
                rv[0] = txd;
                for (int i = 1; i < rn; i++) begin
                    repeat (16) @(negedge clk);
                    rv[i] = txd;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", int'(rv), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rv === frame_vec(e[9], e[8:0]), "R2/R5 received frame",
                        int'(rv), int'(frame_vec(e[9], e[8:0])));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        int gap;
        logic [8:0] d;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; baud_tick = 1'b1;
        tx_en = 0; send_break = 0; nine_bit = 0;
        tdre_ie = 0; tc_ie = 0; irq_mask = 0;
        stat_rd = 0; data_wr = 0; data_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", int'(txd), 1);
        chk(tdre === 1'b1, "R1 tdre", int'(tdre), 1);
        chk(tc === 1'b1, "R1 tc", int'(tc), 1);
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);

        // R11: enabling sends an idle frame, then the held word (R5, R6 unarmed)
        tx_en = 1'b1;
        @(negedge clk);
        chk(tdre === 1'b1, "R6 tdre before write", int'(tdre), 1);
        data_wr = 1'b1; data_in = 9'h035;
        @(negedge clk);
        data_wr = 1'b0;
        chk(tdre === 1'b1, "R6 unarmed write keeps tdre", int'(tdre), 1);
        expect_frame(11'h7FF, 10, 16, 1, "R11 idle frame");
        expect_frame(frame_vec(0, 9'h035), 10, 16, 0, "R11 data after idle");
        chk(tc === 1'b1, "R7 tc after data frame", int'(tc), 1);
        chk(txd === 1'b1, "R13 line rests high", int'(txd), 1);

        // R4 direct load with armed clear (R6)
        write_word(1'b1, 9'h0A6);
        chk(tdre === 1'b1, "R4 tdre after direct load", int'(tdre), 1);
        chk(tc === 1'b0, "R6 armed write clears tc", int'(tc), 0);
        chk(txd === 1'b0, "R4 start bit next cycle", int'(txd), 0);
        expect_frame(frame_vec(0, 9'h0A6), 10, 16, 0, "R2 frame A6");
        chk(tc === 1'b1, "R7 tc set at stop", int'(tc), 1);

        // R5 back-to-back through holding register
        write_word(1'b0, 9'h05A);
        chk(txd === 1'b0, "R4 direct unarmed start", int'(txd), 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; data_wr = 1'b1; data_in = 9'h0C3;
        @(negedge clk);
        data_wr = 1'b0;
        chk(tdre === 1'b0, "R6 armed write to hold clears tdre", int'(tdre), 0);
        chk(tc === 1'b0, "R6 armed write clears tc", int'(tc), 0);
        expect_frame(frame_vec(0, 9'h05A), 10, 16, 2, "R2 frame 5A");
        chk(tdre === 1'b1, "R5 tdre on transfer", int'(tdre), 1);
        chk(tc === 1'b1, "R7 tc at frame end", int'(tc), 1);
        expect_frame(frame_vec(0, 9'h0C3), 10, 16, 0, "R5 held frame no gap");

        // R8 all enable/mask combinations
        for (int k = 0; k < 8; k++) begin
            tdre_ie = k[0]; tc_ie = k[1]; irq_mask = k[2];
            @(negedge clk);
            chk(irq === exp_irq(k[0], k[1], k[2], tdre, tc), "R8 irq combo",
                int'(irq), int'(exp_irq(k[0], k[1], k[2], tdre, tc)));
        end
        tdre_ie = 0; tc_ie = 0; irq_mask = 0;

        // R2 nine-bit frame
        nine_bit = 1'b1;
        write_word(1'b1, 9'h1A5);
        expect_frame(frame_vec(1, 9'h1A5), 11, 16, 0, "R2 nine-bit frame");
        nine_bit = 1'b0;
        @(negedge clk);

        // R9/R10 break frames, marking bit, then held word
        send_break = 1'b1;
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; data_wr = 1'b1; data_in = 9'h081;
        @(negedge clk);
        data_wr = 1'b0;
        chk(tc === 1'b0, "R6 tc cleared during break", int'(tc), 0);
        chk(tdre === 1'b0, "R6 tdre cleared during break", int'(tdre), 0);
        expect_frame(11'h000, 10, 16, 2, "R9 first break");
        chk(tc === 1'b1, "R7 tc after break", int'(tc), 1);
        send_break = 1'b0;
        expect_frame(11'h000, 10, 16, 0, "R9 repeated break");
        expect_frame(11'h7FF, 1, 16, 0, "R10 marking bit");
        chk(tdre === 1'b1, "R10 held word starts after mark", int'(tdre), 1);
        expect_frame(frame_vec(0, 9'h081), 10, 16, 0, "R10 frame after mark");

        // R12 enable toggle mid-frame queues idle frame
        write_word(1'b0, 9'h03C);
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        data_wr = 1'b1; data_in = 9'h099;
        @(negedge clk);
        data_wr = 1'b0;
        expect_frame(frame_vec(0, 9'h03C), 10, 16, 3, "R12 current frame");
        expect_frame(11'h7FF, 10, 16, 0, "R12 idle frame");
        expect_frame(frame_vec(0, 9'h099), 10, 16, 0, "R12 held frame");

        // R13 disabled transmitter holds the word
        tx_en = 1'b0;
        @(negedge clk);
        write_word(1'b0, 9'h077);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (txd !== 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R13 no frame while disabled", bad, 0);
        tx_en = 1'b1;
        @(negedge clk);
        expect_frame(11'h7FF, 10, 16, 0, "R11 idle on enable");
        expect_frame(frame_vec(0, 9'h077), 10, 16, 0, "R13 held word sent");

        // R3 ticks on every other cycle double the bit length
        tick_mode = 1'b1;
        repeat (4) @(negedge clk);
        write_word(1'b0, 9'h06B);
        expect_frame(frame_vec(0, 9'h06B), 10, 32, 0, "R3 gated ticks");
        repeat (100) @(negedge clk);
        tick_mode = 1'b0;
        repeat (4) @(negedge clk);

        // random words, both word lengths
        rx_en = 1'b1;
        for (int blk = 0; blk < 2; blk++) begin
            nine_bit = blk[0];
            @(negedge clk);
            for (int it = 0; it < 15; it++) begin
                gap = $urandom_range(0, 30);
                repeat (gap) @(negedge clk);
                tdre_ie = $urandom_range(0, 1);
                tc_ie = $urandom_range(0, 1);
                irq_mask = $urandom_range(0, 1);
                @(negedge clk);
                chk(irq === exp_irq(tdre_ie, tc_ie, irq_mask, tdre, tc), "R8 irq random",
                    int'(irq), int'(exp_irq(tdre_ie, tc_ie, irq_mask, tdre, tc)));
                while (tdre !== 1'b1) @(negedge clk);
                d = 9'($urandom);
                if (!nine_bit) d[8] = 1'b0;
                exp_q.push_back({nine_bit, d});
                write_word(1'b1, d);
            end
            bad = 0;
            while (exp_q.size() != 0 && bad < 20000) begin
                @(negedge clk);
                bad++;
            end
            chk(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
            repeat (40) @(negedge clk);
        end
        rx_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule